// File: doc/BRIEF.md
# Colour Lookup Palette with Host Byte Port

This block holds a 256-entry colour table, each entry made of red, green and blue components of 8 bits. A host reaches the table through four byte-wide registers picked by a 2-bit select: a pixel mask, a read-index register that returns a state code when read, a write-index register, and one data register shared by reads and writes. Data transfers run in red, green, blue order. After the third byte the index that was used steps by one. A host can therefore stream the whole table in or out after setting one index.

A display path feeds an 8-bit pixel index into the block each cycle. The index is ANDed with the pixel mask and looked up in the table. The colour appears on the output one clock later. If a host commit and a display lookup hit the same entry in the same cycle, the display output holds its previous colour. This hides the tear that a half-updated read would cause.

Top module: `pal_dac_port`

## Requirements
- R1: After reset both indices are 0, both byte sequencers are at red, the state code is 00, the pixel mask is 0xFF and the display output is 0.
- R2: A write with select 2 loads the write index, and a read with select 2 returns the current write index.
- R3: Data writes (select 3) stage red, then green. Only the third (blue) write commits the whole entry to the table. Until then the entry keeps its old colour.
- R4: Each commit steps the write index by one, wrapping 255 to 0. Nothing else moves it except a select-2 write.
- R5: Data reads (select 3) return red, green and blue of the entry at the read index. After the blue read the read index steps by one, wrapping 255 to 0, so 768 reads from index 0 return the whole table.
- R6: A write to either index register returns both byte sequencers to red. A read-index write in the middle of a data write abandons that write, and the entry is left unchanged.
- R7: A read with select 1 returns 0x03 if the read index was written more recently than the write index, and 0x00 otherwise (including after reset). Bits 7:2 are always zero.
- R8: The display lookup uses pixel index AND pixel mask. The mask is written and read back with select 0.
- R9: The display colour for a pixel index presented in one cycle appears on the output after the next rising clock edge, and not before.
- R10: When a commit and the masked display index name the same entry in the same cycle, the display output keeps its previous value for that cycle.
- R11: A data read takes a copy of the whole entry when its red byte is read. Green and blue then come from that copy even if the entry is rewritten before they are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe; wins over hst_rd |
| hst_rd | input | 1 | Host read strobe |
| hst_sel | input | 2 | Register select: 0 mask, 1 read index/state, 2 write index, 3 data |
| hst_wdata | input | DATA_W | Host write byte |
| hst_rdata | output | DATA_W | Host read byte; valid in the cycle hst_rd is high, 0 otherwise |
| pix_idx | input | IDX_W | Display pixel index |
| pix_rgb | output | 3*DATA_W | Display colour, red in the top byte, blue in the bottom byte |

## Verification
The bench builds the block with its default parameters: a 256-entry table and 8-bit components. With these values a full 768-byte fill and readback is short enough to run. That run reaches the 255-to-0 wrap of both indices and every entry of the table. The same 8-bit width lets the bench choose a mask and pixel pair whose raw and masked indices name different entries, so the AND can be seen at the output.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_WIDX = 2'd2,
    SEL_DATA = 2'd3
  } host_sel_e;

  localparam logic [1:0] PH_RED = 2'd0;
  localparam logic [1:0] PH_GRN = 2'd1;
  localparam logic [1:0] PH_BLU = 2'd2;

  // advance the red/green/blue byte sequencer
  function automatic logic [1:0] phase_step(input logic [1:0] ph);
    return (ph == PH_BLU) ? PH_RED : ph + 2'd1;
  endfunction

  // state code byte: both low bits mirror which index was written last
  function automatic logic [7:0] state_code(input logic rd_last);
    return {6'b0, rd_last, rd_last};
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_wr,
  input  logic                  hst_rd,
  input  logic [1:0]            hst_sel,
  input  logic [DATA_W-1:0]     hst_wdata,
  output logic [IDX_W-1:0]      rd_idx,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [1:0]            rd_phase,
  output logic [1:0]            wr_phase,
  output logic                  rd_last,
  output logic [2*DATA_W-1:0]   stage_rg,
  output logic                  commit_we,
  output logic                  rd_fetch
);

  logic data_wr, data_rd, ridx_wr, widx_wr, rd_done;

  always_comb begin
    data_wr   = hst_wr && (hst_sel == SEL_DATA);
    data_rd   = hst_rd && !hst_wr && (hst_sel == SEL_DATA);
    ridx_wr   = hst_wr && (hst_sel == SEL_RIDX);
    widx_wr   = hst_wr && (hst_sel == SEL_WIDX);
    commit_we = data_wr && (wr_phase == PH_BLU);
    rd_fetch  = data_rd && (rd_phase == PH_RED);
    rd_done   = data_rd && (rd_phase == PH_BLU);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx   <= '0;
      wr_idx   <= '0;
      rd_phase <= PH_RED;
      wr_phase <= PH_RED;
      rd_last  <= 1'b0;
      stage_rg <= '0;
    end else if (ridx_wr) begin
      rd_idx   <= hst_wdata[IDX_W-1:0];
      rd_phase <= PH_RED;
      wr_phase <= PH_RED;
      rd_last  <= 1'b1;
    end else if (widx_wr) begin
      wr_idx   <= hst_wdata[IDX_W-1:0];
      rd_phase <= PH_RED;
      wr_phase <= PH_RED;
      rd_last  <= 1'b0;
    end else begin
      if (data_wr) begin
        if (wr_phase == PH_RED) stage_rg[2*DATA_W-1:DATA_W] <= hst_wdata;
        if (wr_phase == PH_GRN) stage_rg[DATA_W-1:0]        <= hst_wdata;
        wr_phase <= phase_step(wr_phase);
        if (commit_we) wr_idx <= wr_idx + IDX_W'(1);
      end
      if (data_rd) begin
        rd_phase <= phase_step(rd_phase);
        if (rd_done) rd_idx <= rd_idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_we,
  input  logic [IDX_W-1:0]      commit_idx,
  input  logic [3*DATA_W-1:0]   commit_rgb,
  input  logic [IDX_W-1:0]      host_idx,
  output logic [3*DATA_W-1:0]   host_rgb,
  input  logic [IDX_W-1:0]      pix_m,
  output logic [3*DATA_W-1:0]   pix_rgb,
  output logic                  collide
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [3*DATA_W-1:0] disp_rgb;

  assign collide = commit_we && (commit_idx == pix_m);

  // one storage lane per colour component (0 = blue, 2 = red)
  for (genvar c = 0; c < 3; c++) begin : g_lane
    logic [DATA_W-1:0] lane_mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (commit_we) lane_mem[commit_idx] <= commit_rgb[c*DATA_W +: DATA_W];
    end

    assign host_rgb[c*DATA_W +: DATA_W] = lane_mem[host_idx];
    assign disp_rgb[c*DATA_W +: DATA_W] = lane_mem[pix_m];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pix_rgb <= '0;
    else if (!collide) pix_rgb <= disp_rgb;
  end

endmodule

// File: rtl/pal_rdpath.sv
module pal_rdpath
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_rd,
  input  logic                  hst_wr,
  input  logic [1:0]            hst_sel,
  input  logic                  rd_fetch,
  input  logic [1:0]            rd_phase,
  input  logic [3*DATA_W-1:0]   host_rgb,
  input  logic [IDX_W-1:0]      mask,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic                  rd_last,
  output logic [DATA_W-1:0]     hst_rdata
);

  logic [2*DATA_W-1:0] snap_gb;
  logic [DATA_W-1:0]   data_byte;
  logic [7:0]          st_byte;

  always_ff @(posedge clk) begin
    if (!rst_n)        snap_gb <= '0;
    else if (rd_fetch) snap_gb <= host_rgb[2*DATA_W-1:0];
  end

  always_comb begin
    st_byte = state_code(rd_last);
    unique case (rd_phase)
      PH_GRN:  data_byte = snap_gb[2*DATA_W-1:DATA_W];
      PH_BLU:  data_byte = snap_gb[DATA_W-1:0];
      default: data_byte = host_rgb[3*DATA_W-1:2*DATA_W];
    endcase
    hst_rdata = '0;
    if (hst_rd && !hst_wr) begin
      unique case (hst_sel)
        SEL_MASK: hst_rdata = DATA_W'(mask);
        SEL_RIDX: hst_rdata = DATA_W'(st_byte);
        SEL_WIDX: hst_rdata = DATA_W'(wr_idx);
        default:  hst_rdata = data_byte;
      endcase
    end
  end

endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hst_wr,
  input  logic                  hst_rd,
  input  logic [1:0]            hst_sel,
  input  logic [DATA_W-1:0]     hst_wdata,
  output logic [DATA_W-1:0]     hst_rdata,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic [3*DATA_W-1:0]   pix_rgb
);

  logic [IDX_W-1:0]    rd_idx, wr_idx, mask, pix_m;
  logic [1:0]          rd_phase, wr_phase;
  logic                rd_last, commit_we, rd_fetch, collide;
  logic [2*DATA_W-1:0] stage_rg;
  logic [3*DATA_W-1:0] host_rgb, commit_rgb;

  always_ff @(posedge clk) begin
    if (!rst_n)                              mask <= '1;
    else if (hst_wr && hst_sel == SEL_MASK)  mask <= hst_wdata[IDX_W-1:0];
  end

  assign pix_m      = pix_idx & mask;
  assign commit_rgb = {stage_rg, hst_wdata};

  pal_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_sel(hst_sel), .hst_wdata(hst_wdata), .rd_idx(rd_idx),
    .wr_idx(wr_idx), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .rd_last(rd_last), .stage_rg(stage_rg), .commit_we(commit_we),
    .rd_fetch(rd_fetch)
  );

  pal_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .commit_we(commit_we), .commit_idx(wr_idx),
    .commit_rgb(commit_rgb), .host_idx(rd_idx), .host_rgb(host_rgb),
    .pix_m(pix_m), .pix_rgb(pix_rgb), .collide(collide)
  );

  pal_rdpath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) rdpath_i (
    .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_sel(hst_sel), .rd_fetch(rd_fetch), .rd_phase(rd_phase),
    .host_rgb(host_rgb), .mask(mask), .wr_idx(wr_idx),
    .rd_last(rd_last), .hst_rdata(hst_rdata)
  );

endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk
  import pal_dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hst_wr,
  input logic [1:0]          hst_sel,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [1:0]          rd_phase,
  input logic [1:0]          wr_phase,
  input logic                rd_last,
  input logic                commit_we,
  input logic                collide,
  input logic [3*DATA_W-1:0] pix_rgb
);

  // R3
  wr_phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase != 2'd3);

  // R5
  rd_phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase != 2'd3);

  // R4
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (wr_phase == PH_RED));

  // R4
  widx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_we && !(hst_wr && hst_sel == SEL_WIDX)) |=> $stable(wr_idx));

  // R6
  seq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && (hst_sel == SEL_RIDX || hst_sel == SEL_WIDX))
      |=> (wr_phase == PH_RED && rd_phase == PH_RED));

  // R7
  state_ridx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_sel == SEL_RIDX) |=> rd_last);

  // R7
  state_widx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_sel == SEL_WIDX) |=> !rd_last);

  // R10
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> $stable(pix_rgb));

endmodule

bind pal_dac_port pal_dac_port_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_sel(hst_sel),
  .wr_idx(wr_idx), .rd_phase(rd_phase), .wr_phase(wr_phase),
  .rd_last(rd_last), .commit_we(commit_we), .collide(collide),
  .pix_rgb(pix_rgb)
);

// File: tb/pal_dac_port_tb.sv
module pal_dac_port_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [1:0]  hst_sel = 2'd0;
  logic [7:0]  hst_wdata = 8'd0;
  logic [7:0]  hst_rdata;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] pix_rgb;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [23:0] exp_pal [256];

  always #2.5 clk = ~clk;

  pal_dac_port dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  function automatic logic [23:0] pat(input int i, input logic [7:0] salt);
    logic [7:0] b = i[7:0];
    return {b ^ salt, ~b, b ^ 8'h5A};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_sel = sel; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_sel = sel;
    #1 d = hst_rdata;
    @(posedge clk); #1;
    hst_rd = 1'b0;
  endtask

  task automatic show(input logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    pix_idx = idx;
    @(posedge clk); #1;
    c = pix_rgb;
  endtask

  task automatic put_rgb(input logic [23:0] c);
    hw(2'd3, c[23:16]); hw(2'd3, c[15:8]); hw(2'd3, c[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pix_rgb", {8'h0, pix_rgb}, 32'h0);
    hr(2'd0, d); check("R1 mask", {24'h0, d}, 32'hFF);
    hr(2'd1, d); check("R7 state after reset", {24'h0, d}, 32'h00);
    hr(2'd2, d); check("R1 write index", {24'h0, d}, 32'h00);
  endtask

  task automatic t_widx();
    logic [7:0] d;
    hw(2'd2, 8'h42);
    hr(2'd2, d); check("R2 write index readback", {24'h0, d}, 32'h42);
    hr(2'd1, d); check("R7 state after write index", {24'h0, d}, 32'h00);
  endtask

  task automatic t_fill();
    logic [7:0] d;
    hw(2'd2, 8'h00);
    for (int i = 0; i < 256; i++) begin
      exp_pal[i] = pat(i, 8'h00);
      put_rgb(exp_pal[i]);
    end
    hr(2'd2, d); check("R4 write index wrap", {24'h0, d}, 32'h00);
  endtask

  task automatic t_readall();
    logic [7:0] d;
    int bad = 0;
    hw(2'd1, 8'h00);
    hr(2'd1, d); check("R7 state after read index", {24'h0, d}, 32'h03);
    for (int i = 0; i < 256; i++) begin
      for (int k = 2; k >= 0; k--) begin
        hr(2'd3, d);
        if (d !== exp_pal[i][k*8 +: 8]) begin
          bad++;
          if (bad < 4) check("R5 sweep byte", {24'h0, d}, {24'h0, exp_pal[i][k*8 +: 8]});
        end
      end
    end
    check("R5 sweep mismatches", bad, 0);
    hr(2'd3, d); check("R5 read index wrap", {24'h0, d}, {24'h0, exp_pal[0][23:16]});
  endtask

  task automatic t_partial();
    logic [7:0] d;
    logic [23:0] c;
    hw(2'd2, 8'd10);
    hw(2'd3, 8'hAA); hw(2'd3, 8'hBB);
    show(8'd10, c); check("R3 partial write not visible", {8'h0, c}, {8'h0, exp_pal[10]});
    hw(2'd1, 8'd10);
    hr(2'd1, d); check("R7 state after abandon", {24'h0, d}, 32'h03);
    hw(2'd3, 8'h11);
    show(8'd10, c); check("R6 abandoned write", {8'h0, c}, {8'h0, exp_pal[10]});
    hw(2'd3, 8'h22); hw(2'd3, 8'h33);
    exp_pal[10] = 24'h112233;
    show(8'd10, c); check("R6 restart at red", {8'h0, c}, 32'h00112233);
    hr(2'd2, d); check("R4 index step", {24'h0, d}, 32'd11);
  endtask

  task automatic t_display();
    logic [7:0] d;
    logic [23:0] c;
    show(8'd20, c); check("R9 lookup", {8'h0, c}, {8'h0, exp_pal[20]});
    @(negedge clk); pix_idx = 8'd21;
    #1 check("R9 not before edge", {8'h0, pix_rgb}, {8'h0, exp_pal[20]});
    @(posedge clk); #1;
    check("R9 after edge", {8'h0, pix_rgb}, {8'h0, exp_pal[21]});
    hw(2'd0, 8'h0F);
    hr(2'd0, d); check("R8 mask readback", {24'h0, d}, 32'h0F);
    show(8'h37, c); check("R8 masked lookup", {8'h0, c}, {8'h0, exp_pal[8'h07]});
    hw(2'd0, 8'hFF);
  endtask

  task automatic t_collide();
    logic [23:0] c;
    show(8'd50, c);
    hw(2'd2, 8'd60);
    hw(2'd3, 8'hC1); hw(2'd3, 8'hC2);
    @(negedge clk);
    hst_wr = 1'b1; hst_sel = 2'd3; hst_wdata = 8'hC3; pix_idx = 8'd60;
    @(posedge clk); #1;
    hst_wr = 1'b0;
    check("R10 hold on collision", {8'h0, pix_rgb}, {8'h0, exp_pal[50]});
    exp_pal[60] = 24'hC1C2C3;
    @(posedge clk); #1;
    check("R10 new colour next cycle", {8'h0, pix_rgb}, 32'h00C1C2C3);
  endtask

  task automatic t_snapshot();
    logic [7:0] d;
    logic [23:0] old;
    old = exp_pal[90];
    hw(2'd2, 8'd90);
    hw(2'd1, 8'd90);
    hr(2'd3, d); check("R11 red", {24'h0, d}, {24'h0, old[23:16]});
    put_rgb(24'h0A0B0C);
    exp_pal[90] = 24'h0A0B0C;
    hr(2'd3, d); check("R11 green from copy", {24'h0, d}, {24'h0, old[15:8]});
    hr(2'd3, d); check("R11 blue from copy", {24'h0, d}, {24'h0, old[7:0]});
    hr(2'd3, d); check("R5 next entry", {24'h0, d}, {24'h0, exp_pal[91][23:16]});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_widx();
    t_fill();
    t_readall();
    t_partial();
    t_display();
    t_collide();
    t_snapshot();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule